// File: doc/BRIEF.md
# Temperature-Indexed Rate Compensation Engine

This block turns each die-temperature reading into a fresh clock-rate correction word. When a measurement-done pulse arrives and compensation is enabled, the signed 11-bit reading is divided by four with an arithmetic shift. The result is limited to a 7-bit signed range. That limited value addresses an external 128-entry table of signed 8-bit corrections.

The table word that comes back is sign-extended and added to the nominal rate constant 0x40000. The 19-bit sum is then split into a 17-bit coarse period field and a 2-bit fine field. Both fields are held in output registers that drive a downstream clock divider.

The table sits outside the block and answers a read strobe one cycle later. Host access to the table is also outside the block. A three-state sequencer (idle, read, load) orders the steps and reports busy while a computation is in flight.

Top module: `tcomp_engine`

## Requirements
- R1: After reset, coarse_o is 0x10000, fine_o is 0, busy_o is 0 and tbl_rd_o is 0.
- R2: A meas_done_i pulse sampled while en_i is low starts nothing. busy_o and tbl_rd_o stay low, and coarse_o and fine_o keep their values.
- R3: The table index is the signed reading temp_i shifted right arithmetically by two, which is floor(temp/4). For example, -1 gives -1 and -5 gives -2.
- R4: The shifted value is limited to the range -64..+63. Readings at or below -256 give -64, and readings at or above 252 give +63.
- R5: tbl_addr_o carries the limited index as a 7-bit two's-complement value. So -64 is 0x40, -1 is 0x7F and +63 is 0x3F.
- R6: The loaded value {coarse_o, fine_o} equals 0x40000 plus the sign-extended 8-bit table word. coarse_o is bits [18:2] and fine_o is bits [1:0].
- R7: Suppose meas_done_i is sampled high with en_i high while idle. Then tbl_rd_o is high for exactly the next cycle. The table word is taken in the cycle after that, and the rate fields update at the following edge. busy_o is high from the edge after the pulse until the rate fields update.
- R8: A meas_done_i pulse sampled while busy_o is high is dropped. It causes no second read and no second load.
- R9: Every enabled measurement reloads the rate fields, including back-to-back measurements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Compensation enable |
| meas_done_i | input | 1 | One-cycle pulse: new temperature valid |
| temp_i | input | 11 | Signed temperature reading |
| tbl_rd_o | output | 1 | Table read strobe |
| tbl_addr_o | output | 7 | Table address (two's-complement index) |
| tbl_data_i | input | 8 | Table word, valid the cycle after tbl_rd_o |
| busy_o | output | 1 | Computation in flight |
| coarse_o | output | 17 | Coarse rate field |
| fine_o | output | 2 | Fine rate field |

## Verification
The assertions assume that the table model returns its word exactly one cycle after tbl_rd_o. They also assume that temp_i holds steady during the cycle in which meas_done_i is sampled. The bench table is a registered memory clocked on the same edge, so the first assumption holds. Inputs change only at falling edges, so the second holds too. Every one of the 2048 possible readings is swept with a fixed table image. That image includes the extreme words 0x80 and 0x7F at the limit addresses.

// File: rtl/tcomp_pkg.sv
package tcomp_pkg;
  localparam int TEMP_W  = 11;
  localparam int SHIFT   = 2;
  localparam int IDX_W   = 7;
  localparam int DATA_W  = 8;
  localparam int FINE_W  = 2;
  localparam int RATE_W  = 19;
  localparam int COARSE_W = RATE_W - FINE_W;
  localparam logic [RATE_W-1:0] NOMINAL = 19'h40000;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_LOAD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tcomp_index.sv
module tcomp_index
  import tcomp_pkg::*;
#(
  parameter int TW = TEMP_W,
  parameter int SH = SHIFT,
  parameter int IW = IDX_W
) (
  input  logic [TW-1:0] temp_i,
  output logic [IW-1:0] idx_o
);
  localparam int SW = TW - SH;
  localparam logic signed [SW-1:0] LIM_HI = SW'((1 <<< (IW-1)) - 1);
  localparam logic signed [SW-1:0] LIM_LO = -SW'(1 <<< (IW-1));

  logic signed [SW-1:0] shifted;

  assign shifted = SW'($signed(temp_i) >>> SH);

  always_comb begin
    if (shifted > LIM_HI)      idx_o = LIM_HI[IW-1:0];
    else if (shifted < LIM_LO) idx_o = LIM_LO[IW-1:0];
    else                       idx_o = shifted[IW-1:0];
  end
endmodule

// File: rtl/tcomp_seq.sv
module tcomp_seq
  import tcomp_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          meas_done_i,
  input  logic [IW-1:0] idx_i,
  output logic          rd_o,
  output logic [IW-1:0] addr_o,
  output logic          load_o,
  output logic          busy_o
);
  seq_state_e state_q, state_d;
  logic       start;

  assign start = (state_q == ST_IDLE) && meas_done_i && en_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_READ;
      ST_READ: state_d = ST_LOAD;
      ST_LOAD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_o  <= '0;
    end else begin
      state_q <= state_d;
      if (start) addr_o <= idx_i;
    end
  end

  assign rd_o   = (state_q == ST_READ);
  assign load_o = (state_q == ST_LOAD);
  assign busy_o = (state_q != ST_IDLE);

  p_rd_follows_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && meas_done_i && en_i) |=> rd_o);
  p_disabled_no_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(meas_done_i && en_i)) |=> !busy_o);
  p_drop_while_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && meas_done_i) |=> !rd_o);
  p_load_after_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> (load_o && $stable(addr_o)));
endmodule

// File: rtl/tcomp_rate_reg.sv
module tcomp_rate_reg
  import tcomp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int RW = RATE_W,
  parameter int FW = FINE_W,
  parameter logic [RW-1:0] NOM = NOMINAL
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [DW-1:0]   corr_i,
  output logic [RW-FW-1:0] coarse_o,
  output logic [FW-1:0]   fine_o
);
  localparam int EXT = RW - DW;
  localparam int CW  = RW - FW;
  localparam logic [CW-1:0] RST_COARSE = NOM[RW-1:FW];
  localparam logic [FW-1:0] RST_FINE   = NOM[FW-1:0];
  localparam logic [CW-1:0] CO_MIN = CW'((NOM - RW'(1 << (DW-1))) >> FW);
  localparam logic [CW-1:0] CO_MAX = CW'((NOM + RW'((1 << (DW-1)) - 1)) >> FW);

  logic [RW-1:0] sum;

  assign sum = NOM + {{EXT{corr_i[DW-1]}}, corr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_o <= RST_COARSE;
      fine_o   <= RST_FINE;
    end else if (load_i) begin
      coarse_o <= sum[RW-1:FW];
      fine_o   <= sum[FW-1:0];
    end
  end

  p_hold_without_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(coarse_o) && $stable(fine_o)));
  p_coarse_in_band_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (coarse_o >= CO_MIN && coarse_o <= CO_MAX));
endmodule

// File: rtl/tcomp_engine.sv
module tcomp_engine
  import tcomp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                meas_done_i,
  input  logic [TEMP_W-1:0]   temp_i,
  output logic                tbl_rd_o,
  output logic [IDX_W-1:0]    tbl_addr_o,
  input  logic [DATA_W-1:0]   tbl_data_i,
  output logic                busy_o,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_o
);
  logic [IDX_W-1:0] idx;
  logic             load;

  tcomp_index #(.TW(TEMP_W), .SH(SHIFT), .IW(IDX_W)) u_index (
    .temp_i (temp_i),
    .idx_o  (idx)
  );

  tcomp_seq #(.IW(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .meas_done_i (meas_done_i),
    .idx_i       (idx),
    .rd_o        (tbl_rd_o),
    .addr_o      (tbl_addr_o),
    .load_o      (load),
    .busy_o      (busy_o)
  );

  tcomp_rate_reg #(.DW(DATA_W), .RW(RATE_W), .FW(FINE_W), .NOM(NOMINAL)) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .corr_i   (tbl_data_i),
    .coarse_o (coarse_o),
    .fine_o   (fine_o)
  );

  p_busy_ends_on_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tbl_rd_o) |=> !busy_o);
endmodule

// File: tb/tcomp_engine_tb_top.sv
module tcomp_engine_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0;
  logic        meas = 0;
  logic [10:0] temp = '0;
  logic        tbl_rd;
  logic [6:0]  tbl_addr;
  logic [7:0]  tbl_q = '0;
  logic        busy;
  logic [16:0] coarse;
  logic [1:0]  fine;
  logic [7:0]  mem [128];
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  tcomp_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .meas_done_i(meas), .temp_i(temp),
    .tbl_rd_o(tbl_rd), .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_q),
    .busy_o(busy), .coarse_o(coarse), .fine_o(fine)
  );

  always_ff @(posedge clk) if (tbl_rd) tbl_q <= mem[tbl_addr];

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_idx(input int t);
    int q = t >>> 2;
    if (q > 63) q = 63;
    if (q < -64) q = -64;
    return q;
  endfunction

  function automatic int exp_rate(input int a);
    return 'h40000 + int'($signed(mem[a]));
  endfunction

  task automatic meas_run(input int t, input bit full);
    int a, r;
    a = exp_idx(t) & 'h7f;
    r = exp_rate(a);
    @(negedge clk); temp = 11'(t); meas = 1;
    @(negedge clk); meas = 0;
    if (full) begin
      chk("R7 rd", int'(tbl_rd), 1);
      chk("R7 busy", int'(busy), 1);
    end
    chk("R3 R4 R5 addr", int'(tbl_addr), a);
    @(negedge clk);
    if (full) chk("R7 rd one cycle", int'(tbl_rd), 0);
    @(negedge clk);
    chk("R6 coarse", int'(coarse), r >> 2);
    chk("R6 fine", int'(fine), r & 3);
    if (full) chk("R7 busy end", int'(busy), 0);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 128; a++) mem[a] = 8'(a * 37 + 11);
    mem['h40] = 8'h80;
    mem['h3f] = 8'h7f;
    mem[0]    = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 coarse", int'(coarse), 'h10000);
    chk("R1 fine", int'(fine), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 rd", int'(tbl_rd), 0);
    rst_n = 1;
    // R2 disabled pulse ignored
    @(negedge clk); temp = 11'(400); meas = 1;
    @(negedge clk); meas = 0;
    chk("R2 busy", int'(busy), 0);
    chk("R2 rd", int'(tbl_rd), 0);
    repeat (2) @(negedge clk);
    chk("R2 coarse", int'(coarse), 'h10000);
    chk("R2 fine", int'(fine), 0);
    en = 1;
    // R3 R4 R5 corner readings
    meas_run(-1, 1);
    meas_run(-5, 1);
    meas_run(-256, 1);
    meas_run(-257, 1);
    meas_run(-1024, 1);
    meas_run(251, 1);
    meas_run(252, 1);
    meas_run(1023, 1);
    meas_run(0, 1);
    // R9 full sweep, back-to-back measurements
    for (int t = -1024; t < 1024; t++) meas_run(t, t[0]);
    // R8 pulse while busy dropped
    meas_run(100, 1);
    @(negedge clk); temp = 11'(-300); meas = 1;
    @(negedge clk); temp = 11'(200);
    @(negedge clk); meas = 0;
    chk("R8 no rd while busy", int'(tbl_rd), 0);
    @(negedge clk);
    chk("R8 idle", int'(busy), 0);
    @(negedge clk);
    chk("R8 no restart", int'(busy), 0);
    chk("R8 rate", int'({coarse, fine}), exp_rate(exp_idx(-300) & 'h7f));
    // R2 disable after updates: hold
    en = 0;
    @(negedge clk); temp = 11'(0); meas = 1;
    @(negedge clk); meas = 0;
    repeat (3) @(negedge clk);
    chk("R2 hold", int'({coarse, fine}), exp_rate(exp_idx(-300) & 'h7f));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule